// File: doc/BRIEF.md
# MSI-to-LPI Translation Table Walker

This block turns a message-signalled interrupt into a physical LPI number and the base address of the redistributor that must receive it. A peripheral starts a translation by writing its event ID to the translate register at offset 0x10040 of the block's register window. The control frame sits at offset 0 and the translation frame 0x10000 above it. The device ID travels with the write as a side-band value. The walker then makes three dependent reads over a simple memory read port. It reads the device entry indexed by device ID, then the interrupt translation entry indexed by event ID, then the collection entry named by that translation entry.

Every level is checked before the next read is issued. An entry may be invalid, an ID may be out of range, or the interrupt may be virtual. In each of these cases the walk ends with a one-cycle error strobe and a code, and no interrupt is produced. When the walk succeeds, the block gives one strobe that carries the interrupt number and the redistributor base. Only one translation runs at a time. A translate write that arrives while a walk is running is dropped.

Top module: `msi_walker`

## Requirements
- R1: A walk starts only on a write whose address equals 0x10040. A write to any other address produces no memory request and no output strobe.
- R2: The reads are issued in a fixed order. The first is at device base + device ID × 8. The second is at translation-table address + event ID × 8. The third is at collection base + collection ID × 8. Addresses are truncated to the address width.
- R3: A device entry uses bit 0 as valid, bits 52:1 as the translation-table address and bits 57:53 as the event-ID range (number of event-ID bits minus one). If valid = 0, the walk ends with error code 3 and no further reads.
- R4: The walk ends with error code 4 after the device read, and makes no further reads, in either of two cases. The first is an event ID with a bit set at or above position range+1. The second is an event ID with a bit set at or above the implemented event-ID width.
- R5: A device ID with a bit set at or above the implemented device-ID width ends the walk with error code 1. No memory read is made.
- R6: When the indirect-table configuration input is high, any translation ends with error code 2 and makes no memory read. This code takes priority over code 1.
- R7: A translation entry uses bit 0 as valid, bit 1 as type (1 = physical), bits 15:2 as the interrupt number and bits 45:30 as the collection ID. If valid = 0, the walk ends with code 5. If valid = 1 and type = 0, it ends with code 6. Neither case makes a collection read.
- R8: A collection entry uses bit 0 as valid and bits 40:1 as the redistributor base. If valid = 0, the walk ends with code 7.
- R9: A successful walk raises the LPI strobe for exactly one cycle, in the cycle after the collection response. The strobe carries the interrupt number and the redistributor base.
- R10: A memory request stays asserted with a stable address until it is accepted. The walker waits any number of cycles for each response.
- R11: A translate write that arrives while a walk is in progress is ignored.
- R12: The error strobe lasts one cycle, carries the code, and is never high in the same cycle as the LPI strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_wr | input | 1 | Register write strobe |
| msg_addr | input | 17 | Register write offset within the block window |
| msg_dev_id | input | 32 | Device ID of the writing peripheral |
| msg_event_id | input | 32 | Write data: event ID |
| cfg_dev_base | input | AW | Device table base address |
| cfg_coll_base | input | AW | Collection table base address |
| cfg_indirect | input | 1 | Two-level table requested (not supported) |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Read byte address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Read data (one table entry) |
| lpi_valid | output | 1 | One-cycle success strobe |
| lpi_intid | output | 14 | Translated interrupt number |
| lpi_rd_base | output | 40 | Target redistributor base |
| err_valid | output | 1 | One-cycle error strobe |
| err_code | output | 3 | Error reason (1..7) |

## Verification
The bench builds the walker with a 6-bit device-ID width and a 10-bit event-ID width, keeping the 52-bit address width. Random device IDs up to 79 therefore cross the 64-entry device limit regularly. Random event IDs up to 1499 cross both the per-device range and the 1024-entry implemented limit. This makes the two range rejections frequent under random stimulus rather than needing hand-picked values. Directed cases cover the exact boundaries: device 63 and 64, event 2^(range+1), range 31 against the implemented width, and the indirect-over-device priority.

// File: rtl/msi_walk_pkg.sv
package msi_walk_pkg;

  typedef enum logic [2:0] {
    ERR_NONE          = 3'd0,
    ERR_DEV_RANGE     = 3'd1,
    ERR_INDIRECT      = 3'd2,
    ERR_DTE_INVALID   = 3'd3,
    ERR_EVT_RANGE     = 3'd4,
    ERR_ITTE_INVALID  = 3'd5,
    ERR_VIRTUAL       = 3'd6,
    ERR_CTE_INVALID   = 3'd7
  } walk_err_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV_REQ, S_DEV_WAIT, S_ITT_REQ, S_ITT_WAIT, S_COL_REQ, S_COL_WAIT
  } walk_state_e;

  localparam int unsigned FRAME_AW = 17;
  localparam logic [FRAME_AW-1:0] TRANSLATE_OFFSET = 17'h10040;

  // Byte address of an 8-byte entry in a flat table.
  function automatic logic [63:0] entry_addr(input logic [63:0] base, input logic [31:0] id);
    return base + {29'd0, id, 3'b000};
  endfunction

  // True when id has any bit at or above position nbits.
  function automatic logic id_exceeds(input logic [31:0] id, input logic [5:0] nbits);
    if (nbits >= 6'd32) return 1'b0;
    return (id >> nbits) != 32'd0;
  endfunction

  function automatic logic        dte_valid(input logic [63:0] e); return e[0];     endfunction
  function automatic logic [51:0] dte_itt_addr(input logic [63:0] e); return e[52:1]; endfunction
  function automatic logic [4:0]  dte_range(input logic [63:0] e); return e[57:53]; endfunction

  function automatic logic        itte_valid(input logic [63:0] e); return e[0];     endfunction
  function automatic logic        itte_phys(input logic [63:0] e);  return e[1];     endfunction
  function automatic logic [13:0] itte_intid(input logic [63:0] e); return e[15:2];  endfunction
  function automatic logic [15:0] itte_cid(input logic [63:0] e);   return e[45:30]; endfunction

  function automatic logic        cte_valid(input logic [63:0] e);  return e[0];     endfunction
  function automatic logic [39:0] cte_rdbase(input logic [63:0] e); return e[40:1];  endfunction

endpackage

// File: rtl/msi_trigger.sv
module msi_trigger
  import msi_walk_pkg::*;
#(
  parameter int unsigned ADDR_BITS = FRAME_AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 msg_wr,
  input  logic [ADDR_BITS-1:0] msg_addr,
  input  logic                 busy,
  output logic                 start
);
  localparam logic [ADDR_BITS-1:0] HIT_ADDR = ADDR_BITS'(TRANSLATE_OFFSET);

  logic addr_hit;
  assign addr_hit = (msg_addr == HIT_ADDR);
  assign start    = msg_wr && addr_hit && !busy;

  // R1: a write elsewhere in the window never launches a walk
  p_miss_no_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_wr && !addr_hit) |-> !start);
endmodule

// File: rtl/msi_walk_ctrl.sv
module msi_walk_ctrl
  import msi_walk_pkg::*;
#(
  parameter int unsigned AW         = 52,
  parameter int unsigned DEV_BITS   = 16,
  parameter int unsigned EVENT_BITS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   in_dev_id,
  input  logic [31:0]   in_event_id,
  input  logic [AW-1:0] cfg_dev_base,
  input  logic [AW-1:0] cfg_coll_base,
  input  logic          cfg_indirect,
  output logic          busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [63:0]   mem_rsp_data,
  output logic          lpi_valid,
  output logic [13:0]   lpi_intid,
  output logic [39:0]   lpi_rd_base,
  output logic          err_valid,
  output logic [2:0]    err_code
);
  localparam logic [5:0] DEV_W = 6'(DEV_BITS);
  localparam logic [5:0] EVT_W = 6'(EVENT_BITS);

  walk_state_e   state_q, state_d;
  logic [31:0]   ev_q;
  logic [AW-1:0] addr_q, addr_d;
  logic          load_addr;
  logic [13:0]   intid_q;
  logic          fail, done;
  walk_err_e     fail_code;

  logic lpi_v_q, err_v_q;
  logic [13:0] lpi_id_q;
  logic [39:0] lpi_rd_q;
  logic [2:0]  err_c_q;

  // Named internal events
  logic dev_over, evt_over, rsp_take;
  assign dev_over = id_exceeds(in_dev_id, DEV_W);
  assign evt_over = id_exceeds(ev_q, 6'(dte_range(mem_rsp_data)) + 6'd1) || id_exceeds(ev_q, EVT_W);
  assign rsp_take = mem_rsp_valid &&
                    (state_q == S_DEV_WAIT || state_q == S_ITT_WAIT || state_q == S_COL_WAIT);

  assign busy          = (state_q != S_IDLE);
  assign mem_req_valid = (state_q == S_DEV_REQ) || (state_q == S_ITT_REQ) || (state_q == S_COL_REQ);
  assign mem_req_addr  = addr_q;

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    load_addr = 1'b0;
    fail      = 1'b0;
    fail_code = ERR_NONE;
    done      = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        if (cfg_indirect) begin
          fail = 1'b1; fail_code = ERR_INDIRECT;
        end else if (dev_over) begin
          fail = 1'b1; fail_code = ERR_DEV_RANGE;
        end else begin
          load_addr = 1'b1;
          addr_d    = AW'(entry_addr(64'(cfg_dev_base), in_dev_id));
          state_d   = S_DEV_REQ;
        end
      end
      S_DEV_REQ: if (mem_req_ready) state_d = S_DEV_WAIT;
      S_ITT_REQ: if (mem_req_ready) state_d = S_ITT_WAIT;
      S_COL_REQ: if (mem_req_ready) state_d = S_COL_WAIT;
      S_DEV_WAIT: if (mem_rsp_valid) begin
        if (!dte_valid(mem_rsp_data)) begin
          fail = 1'b1; fail_code = ERR_DTE_INVALID;
        end else if (evt_over) begin
          fail = 1'b1; fail_code = ERR_EVT_RANGE;
        end else begin
          load_addr = 1'b1;
          addr_d    = AW'(entry_addr(64'(dte_itt_addr(mem_rsp_data)), ev_q));
          state_d   = S_ITT_REQ;
        end
      end
      S_ITT_WAIT: if (mem_rsp_valid) begin
        if (!itte_valid(mem_rsp_data)) begin
          fail = 1'b1; fail_code = ERR_ITTE_INVALID;
        end else if (!itte_phys(mem_rsp_data)) begin
          fail = 1'b1; fail_code = ERR_VIRTUAL;
        end else begin
          load_addr = 1'b1;
          addr_d    = AW'(entry_addr(64'(cfg_coll_base), 32'(itte_cid(mem_rsp_data))));
          state_d   = S_COL_REQ;
        end
      end
      S_COL_WAIT: if (mem_rsp_valid) begin
        if (!cte_valid(mem_rsp_data)) begin
          fail = 1'b1; fail_code = ERR_CTE_INVALID;
        end else begin
          done    = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (fail) state_d = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      ev_q     <= '0;
      addr_q   <= '0;
      intid_q  <= '0;
      lpi_v_q  <= 1'b0;
      lpi_id_q <= '0;
      lpi_rd_q <= '0;
      err_v_q  <= 1'b0;
      err_c_q  <= '0;
    end else begin
      state_q <= state_d;
      lpi_v_q <= done;
      err_v_q <= fail;
      if (load_addr) addr_q <= addr_d;
      if (state_q == S_IDLE && start) ev_q <= in_event_id;
      if (state_q == S_ITT_WAIT && mem_rsp_valid) intid_q <= itte_intid(mem_rsp_data);
      if (fail) err_c_q <= fail_code;
      if (done) begin
        lpi_id_q <= intid_q;
        lpi_rd_q <= cte_rdbase(mem_rsp_data);
      end
    end
  end

  assign lpi_valid   = lpi_v_q;
  assign lpi_intid   = lpi_id_q;
  assign lpi_rd_base = lpi_rd_q;
  assign err_valid   = err_v_q;
  assign err_code    = err_c_q;

  // R10: a stalled request keeps its address
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R9: success strobe is a single cycle
  p_lpi_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lpi_valid |=> !lpi_valid);
  // R12: error and success never coincide; error leaves the walker idle
  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(lpi_valid && err_valid));
  p_err_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> !mem_req_valid);
  // R5: out-of-range device never reaches memory
  p_dev_noreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && dev_over) |=> (!mem_req_valid && err_valid));
  // R2: a response only ever follows an accepted request
  p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
  // R7: walk may only complete from the collection wait
  p_done_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && state_q != S_COL_WAIT) |=> !lpi_valid);
endmodule

// File: rtl/msi_walker.sv
module msi_walker
  import msi_walk_pkg::*;
#(
  parameter int unsigned AW         = 52,
  parameter int unsigned DEV_BITS   = 16,
  parameter int unsigned EVENT_BITS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                msg_wr,
  input  logic [FRAME_AW-1:0] msg_addr,
  input  logic [31:0]         msg_dev_id,
  input  logic [31:0]         msg_event_id,
  input  logic [AW-1:0]       cfg_dev_base,
  input  logic [AW-1:0]       cfg_coll_base,
  input  logic                cfg_indirect,
  output logic                busy,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [AW-1:0]       mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [63:0]         mem_rsp_data,
  output logic                lpi_valid,
  output logic [13:0]         lpi_intid,
  output logic [39:0]         lpi_rd_base,
  output logic                err_valid,
  output logic [2:0]          err_code
);
  logic start_fire;

  msi_trigger #(.ADDR_BITS(FRAME_AW)) u_trigger (
    .clk      (clk),
    .rst_n    (rst_n),
    .msg_wr   (msg_wr),
    .msg_addr (msg_addr),
    .busy     (busy),
    .start    (start_fire)
  );

  msi_walk_ctrl #(.AW(AW), .DEV_BITS(DEV_BITS), .EVENT_BITS(EVENT_BITS)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start_fire),
    .in_dev_id     (msg_dev_id),
    .in_event_id   (msg_event_id),
    .cfg_dev_base  (cfg_dev_base),
    .cfg_coll_base (cfg_coll_base),
    .cfg_indirect  (cfg_indirect),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .lpi_valid     (lpi_valid),
    .lpi_intid     (lpi_intid),
    .lpi_rd_base   (lpi_rd_base),
    .err_valid     (err_valid),
    .err_code      (err_code)
  );

  // R1: an accepted translate write either starts a walk or reports at once
  p_start_takes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> (busy || err_valid));
  // R6: indirect configuration fails before any read
  p_indirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_fire && cfg_indirect) |=> (err_valid && err_code == 3'd2 && !mem_req_valid));
  // R11: busy walker drops further writes
  p_busy_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && msg_wr) |-> !start_fire);
endmodule

// File: tb/msi_walker_test.sv
`timescale 1ns/1ps
module msi_walker_test;
  localparam int AW = 52;
  localparam int DEVB = 6;
  localparam int EVB = 10;
  localparam longint AMASK = (64'd1 << AW) - 1;

  logic clk = 0, rst_n = 0;
  logic msg_wr = 0;
  logic [16:0] msg_addr = 0;
  logic [31:0] msg_dev_id = 0, msg_event_id = 0;
  logic [AW-1:0] cfg_dev_base = 0, cfg_coll_base = 0;
  logic cfg_indirect = 0;
  logic busy, mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [AW-1:0] mem_req_addr;
  logic [63:0] mem_rsp_data = 0;
  logic lpi_valid, err_valid;
  logic [13:0] lpi_intid;
  logic [39:0] lpi_rd_base;
  logic [2:0] err_code;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  msi_walker #(.AW(AW), .DEV_BITS(DEVB), .EVENT_BITS(EVB)) uut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_dte(bit v, logic [51:0] a, logic [4:0] r);
    return (64'(r) << 53) | (64'(a) << 1) | 64'(v);
  endfunction
  function automatic logic [63:0] mk_itte(bit v, bit p, logic [13:0] id, logic [15:0] c);
    return (64'(c) << 30) | (64'(id) << 2) | (64'(p) << 1) | 64'(v);
  endfunction
  function automatic logic [63:0] mk_cte(bit v, logic [39:0] rd);
    return (64'(rd) << 1) | 64'(v);
  endfunction
  function automatic string req_of(int code);
    case (code)
      0: return "R9";  1: return "R5";  2: return "R6";  3: return "R3";
      4: return "R4";  5, 6: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic run_case(input logic [31:0] dev, input logic [31:0] ev,
                          input logic [63:0] dte, input logic [63:0] itte, input logic [63:0] cte,
                          input bit ind, input bit poke);
    int ecode, enr, nreq, wcnt;
    longint eaddr[3];
    logic [63:0] data[3];
    longint got[3];
    bit hs, armed, held, stable_ok, seen;
    logic [AW-1:0] hold_a;
    int gcode; bit glpi; logic [13:0] gid; logic [39:0] grd;
    longint rng;
    data[0] = dte; data[1] = itte; data[2] = cte;
    // expected outcome
    enr = 0; ecode = 0;
    eaddr[0] = (longint'(cfg_dev_base) + longint'(dev) * 8) & AMASK;
    eaddr[1] = (longint'(dte[52:1]) + longint'(ev) * 8) & AMASK;
    eaddr[2] = (longint'(cfg_coll_base) + longint'(itte[45:30]) * 8) & AMASK;
    rng = longint'(dte[57:53]) + 1;
    if (ind) ecode = 2;
    else if (longint'(dev) >= (64'd1 << DEVB)) ecode = 1;
    else begin
      enr = 1;
      if (!dte[0]) ecode = 3;
      else if (longint'(ev) >= (64'd1 << rng) || longint'(ev) >= (64'd1 << EVB)) ecode = 4;
      else begin
        enr = 2;
        if (!itte[0]) ecode = 5;
        else if (!itte[1]) ecode = 6;
        else begin
          enr = 3;
          if (!cte[0]) ecode = 7;
        end
      end
    end
    // launch
    @(negedge clk);
    cfg_indirect = ind; msg_wr = 1; msg_addr = 17'h10040; msg_dev_id = dev; msg_event_id = ev;
    nreq = 0; hs = 0; armed = 0; held = 0; stable_ok = 1; seen = 0; wcnt = 0;
    gcode = -1; glpi = 0; gid = 0; grd = 0;
    for (int k = 0; k < 300 && !seen; k++) begin
      @(negedge clk);
      msg_wr = 0; mem_rsp_valid = 0;
      if (poke && k == 0 && enr > 0) begin
        msg_wr = 1; msg_dev_id = dev ^ 32'h1; msg_event_id = ev ^ 32'h3;
      end
      if (lpi_valid || err_valid) begin
        seen = 1; glpi = lpi_valid; gid = lpi_intid; grd = lpi_rd_base;
        gcode = err_valid ? int'(err_code) : 0;
        if (lpi_valid && err_valid) chk(0, "R12", 1, 0);
      end
      if (hs) begin
        hs = 0; mem_req_ready = 0; armed = 1; wcnt = $urandom % 4;
      end
      if (armed) begin
        if (wcnt == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = data[nreq-1]; armed = 0;
        end else wcnt--;
      end else if (mem_req_valid) begin
        if (held && mem_req_addr != hold_a) stable_ok = 0;
        if ($urandom % 3 == 0) begin
          mem_req_ready = 1; held = 0;
          if (nreq < 3) got[nreq] = longint'(mem_req_addr);
          nreq++; hs = 1;
        end else begin
          held = 1; hold_a = mem_req_addr;
        end
      end
    end
    msg_wr = 0; mem_rsp_valid = 0; mem_req_ready = 0;
    chk(seen, "R12 outcome strobe seen", seen, 1);
    chk(gcode == ecode, req_of(ecode), gcode, ecode);
    chk(nreq == enr, poke ? "R11 read count" : "R2 read count", nreq, enr);
    for (int i = 0; i < 3; i++)
      if (i < enr && i < nreq) chk(got[i] == eaddr[i], "R2 address", got[i], eaddr[i]);
    if (ecode == 0) begin
      chk(glpi, "R9 strobe", glpi, 1);
      chk(gid == itte[15:2], "R9 intid", gid, itte[15:2]);
      chk(grd == cte[40:1], "R9 rd base", grd, cte[40:1]);
    end
    chk(stable_ok, "R10 held address", stable_ok, 1);
    @(negedge clk);
    chk(!lpi_valid && !err_valid, "R12 single-cycle strobe", {lpi_valid, err_valid}, 0);
    chk(!busy, "R11 idle after walk", busy, 0);
  endtask

  task automatic miss_write(input logic [16:0] a);
    bit bad;
    @(negedge clk);
    cfg_indirect = 0; msg_wr = 1; msg_addr = a; msg_dev_id = 1; msg_event_id = 1;
    @(negedge clk); msg_wr = 0;
    bad = 0;
    for (int k = 0; k < 5; k++) begin
      if (mem_req_valid || lpi_valid || err_valid || busy) bad = 1;
      @(negedge clk);
    end
    chk(!bad, "R1 ignored address", bad, 0);
  endtask

  initial begin
    #(20.0 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [51:0] ia;
    void'($urandom(32'h1234));
    cfg_dev_base = 52'h0_1000_0000; cfg_coll_base = 52'h0_2000_0000;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req_valid && !lpi_valid && !err_valid, "R12 reset state",
        {busy, mem_req_valid, lpi_valid, err_valid}, 0);
    rst_n = 1;
    ia = 52'h0_3000_0000;
    // R1
    miss_write(17'h00040); miss_write(17'h10044); miss_write(17'h10000);
    // R9 basic success
    run_case(5, 7, mk_dte(1, ia, 4), mk_itte(1, 1, 14'h2345, 16'h0012), mk_cte(1, 40'hAB_CDEF_0123), 0, 0);
    // R6 priority over R5
    run_case(100, 0, mk_dte(1, ia, 4), mk_itte(1, 1, 1, 1), mk_cte(1, 1), 1, 0);
    run_case(3, 0, mk_dte(1, ia, 4), mk_itte(1, 1, 1, 1), mk_cte(1, 1), 1, 0);
    // R5 boundary
    run_case(63, 1, mk_dte(1, ia, 2), mk_itte(1, 1, 9, 3), mk_cte(1, 40'h55), 0, 0);
    run_case(64, 1, mk_dte(1, ia, 2), mk_itte(1, 1, 9, 3), mk_cte(1, 40'h55), 0, 0);
    // R3
    run_case(2, 1, mk_dte(0, ia, 2), mk_itte(1, 1, 9, 3), mk_cte(1, 40'h55), 0, 0);
    // R4 boundary: range 2 => 3 bits
    run_case(2, 7, mk_dte(1, ia, 2), mk_itte(1, 1, 9, 3), mk_cte(1, 40'h55), 0, 0);
    run_case(2, 8, mk_dte(1, ia, 2), mk_itte(1, 1, 9, 3), mk_cte(1, 40'h55), 0, 0);
    run_case(2, 1023, mk_dte(1, ia, 31), mk_itte(1, 1, 9, 3), mk_cte(1, 40'h55), 0, 0);
    run_case(2, 1024, mk_dte(1, ia, 31), mk_itte(1, 1, 9, 3), mk_cte(1, 40'h55), 0, 0);
    // R7
    run_case(4, 2, mk_dte(1, ia, 5), mk_itte(0, 1, 9, 3), mk_cte(1, 40'h55), 0, 0);
    run_case(4, 2, mk_dte(1, ia, 5), mk_itte(1, 0, 9, 3), mk_cte(1, 40'h55), 0, 0);
    // R8
    run_case(4, 2, mk_dte(1, ia, 5), mk_itte(1, 1, 9, 16'hFFFF), mk_cte(0, 40'h55), 0, 0);
    // R11 write while busy
    run_case(9, 3, mk_dte(1, ia, 7), mk_itte(1, 1, 14'h3FFF, 16'h8001), mk_cte(1, 40'hFF_FFFF_FFFF), 0, 1);
    // random
    for (int n = 0; n < 300; n++) begin
      logic [51:0] ra;
      ra = {$urandom, $urandom} & 52'hF_FFFF_FFFF_FFFF;
      run_case($urandom % 80, $urandom % 1500,
               mk_dte(($urandom % 8) != 0, ra, 5'($urandom % 12)),
               mk_itte(($urandom % 8) != 0, ($urandom % 6) != 0, 14'($urandom), 16'($urandom)),
               mk_cte(($urandom % 8) != 0, {8'($urandom), 32'($urandom)}),
               ($urandom % 25) == 0, ($urandom % 5) == 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule